// File: doc/BRIEF.md
# Message Channel FIFO Status Controller

This block sits between a processor's register bus and a switch link. Software pushes 128-bit words toward the link through an outgoing FIFO and pulls 128-bit words that arrive from the link out of an incoming FIFO. The outgoing FIFO holds 60 words by default. A word written through the close address is tagged as the last word of its frame, and that tag travels with the word to the link.

A status register combines two kinds of bits. Some are live FIFO flags, such as occupancy, almost-full and almost-empty, together with the arming state of two external DMA engines. Others are sticky bits that software clears by writing one to them: the two block-complete events and an overflow flag. Two interrupt lines are formed from these bits with fixed equations. The receive line is held off while incoming DMA is armed. The transmit line is driven by a completed frame, or by an empty outgoing FIFO when a mode bit enables that source.

The register bus uses valid, write, address and write-data signals. Read data is registered and appears on the cycle after the read request. Between reads it returns to zero.

Top module: `msg_chan_ctrl`

## Requirements
- R1: After reset both FIFOs are empty, `tx_valid` is 0, `rx_ready` is 1, both interrupts are 0, the mode register reads 0 and the status register reads 0x1200 (only the outgoing-empty and incoming-low bits are set).
- R2: Address map (word address on `host_addr`): 0 is the data FIFO port, 1 is the close FIFO port, 2 is the status register and 3 is the mode register. Words written to address 0 or 1 leave on `tx_data` in write order. `tx_last` is 1 exactly for words that were written through address 1. A word leaves on each cycle in which `tx_valid` and `tx_ready` are both 1.
- R3: Status bit 11 is 1 while the outgoing FIFO holds OUT_DEPTH words. A write to address 0 or 1 while the FIFO is full is dropped and sets the sticky overflow bit, status bit 16. That bit stays set until a write to address 2 with bit 16 set.
- R4: Status bit 10 (outgoing almost-full) is 1 when the outgoing FIFO has 4 or fewer free entries, and 0 otherwise. Status bit 12 is 1 while the outgoing FIFO is empty.
- R5: Words accepted from the link (`rx_valid` and `rx_ready` both 1) are returned in arrival order by reads of address 0 or 1. The data appears on `host_rdata` one cycle after the request. A read of an empty incoming FIFO returns 0. `rx_ready` is 0 while the incoming FIFO holds IN_DEPTH words.
- R6: Status bit 8 is 1 while the incoming FIFO is not empty. Status bit 9 is 1 while the incoming FIFO holds at most one word.
- R7: Status bit 6 (transmit complete) is set when a close-tagged word leaves on the link. Status bit 7 (receive complete) is set when software reads a close-tagged word. Writing 1 to either bit at address 2 clears it, and writing 0 leaves it unchanged.
- R8: `irq_rx` = (bit 7 or bit 8) and not `dma_in_armed`.
- R9: `irq_tx` = (bit 6 and not bit 10) or (bit 12 and mode bit 0). Mode bit 0 is written at address 3 and reads back there.
- R10: Status bits 13 and 14 follow `dma_in_armed` and `dma_out_armed`. Bit 15 and all bits other than 6 to 14 and 16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Register access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Word address |
| host_wdata | input | 128 | Write data |
| host_rdata | output | 128 | Read data, one cycle after the request |
| tx_valid | output | 1 | Outgoing word available |
| tx_ready | input | 1 | Link accepts the outgoing word |
| tx_data | output | 128 | Outgoing word |
| tx_last | output | 1 | Outgoing word closes its frame |
| rx_valid | input | 1 | Incoming word offered |
| rx_ready | output | 1 | Incoming FIFO has room |
| rx_data | input | 128 | Incoming word |
| rx_last | input | 1 | Incoming word closes its frame |
| dma_in_armed | input | 1 | Incoming DMA engine armed |
| dma_out_armed | input | 1 | Outgoing DMA engine armed |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bench fills the outgoing FIFO one word at a time and reads the status register at 55 and at 56 words. A design that computes the almost-full margin off by one shows the flip at the wrong point, and the transmit interrupt gating follows it. A write into the full FIFO must leave no trace in the drained stream, so a design that overwrites the oldest entry fails the scoreboard order check. The bench checks the write-one-to-clear bits with an all-zero write and then a one, which catches a design that clears on any write to the register. It also drives the incoming FIFO to full and reads it past empty, which exposes stale read data and a missing back-pressure signal.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    localparam int WORD_W = 128;
    localparam int ADDR_W = 2;
    localparam int STAT_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DATA = 2'd0,
        ADR_CLOSE = 2'd1,
        ADR_STAT = 2'd2,
        ADR_MODE = 2'd3
    } mcc_addr_e;

    // status bit positions; software decodes these
    localparam int S_TX_DONE  = 6;
    localparam int S_RX_DONE  = 7;
    localparam int S_RX_PEND  = 8;
    localparam int S_RX_LOW   = 9;
    localparam int S_TX_HIGH  = 10;
    localparam int S_TX_FULL  = 11;
    localparam int S_TX_EMPTY = 12;
    localparam int S_DMA_IN   = 13;
    localparam int S_DMA_OUT  = 14;
    localparam int S_TX_OVF   = 16;
    localparam int M_EMPTY_EN = 0;
endpackage

// File: rtl/mcc_fifo.sv
module mcc_fifo #(
    parameter int DEPTH = 60,
    parameter int W     = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       push_last,
    input  logic                       pop,
    output logic [W-1:0]               head_data,
    output logic                       head_last,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign {head_last, head_data} = mem[rptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= {push_last, push_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mcc_status.sv
module mcc_status
    import mcc_pkg::*;
#(
    parameter int OUT_DEPTH    = 60,
    parameter int IN_DEPTH     = 16,
    parameter int TX_HIGH_FREE = 4,
    parameter int RX_LOW_WORDS = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tx_close_evt,
    input  logic                           rx_close_evt,
    input  logic                           ovf_evt,
    input  logic                           stat_wr,
    input  logic                           mode_wr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [$clog2(OUT_DEPTH+1)-1:0] out_count,
    input  logic [$clog2(IN_DEPTH+1)-1:0]  in_count,
    input  logic                           dma_in_armed,
    input  logic                           dma_out_armed,
    output logic [STAT_W-1:0]              stat_word,
    output logic                           empty_en,
    output logic                           tx_done_q,
    output logic                           ovf_q,
    output logic                           tx_empty,
    output logic                           irq_rx,
    output logic                           irq_tx
);
    logic rx_done_q, rx_pend, rx_low, tx_high, tx_full;

    assign rx_pend  = (in_count != '0);
    assign rx_low   = (int'(in_count) <= RX_LOW_WORDS);
    assign tx_high  = (int'(out_count) >= OUT_DEPTH - TX_HIGH_FREE);
    assign tx_full  = (int'(out_count) == OUT_DEPTH);
    assign tx_empty = (out_count == '0);

    // event bits: a new event in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done_q <= 1'b0;
            rx_done_q <= 1'b0;
            ovf_q     <= 1'b0;
            empty_en  <= 1'b0;
        end else begin
            tx_done_q <= tx_close_evt | (tx_done_q & ~(stat_wr & wdata[S_TX_DONE]));
            rx_done_q <= rx_close_evt | (rx_done_q & ~(stat_wr & wdata[S_RX_DONE]));
            ovf_q     <= ovf_evt      | (ovf_q     & ~(stat_wr & wdata[S_TX_OVF]));
            if (mode_wr) empty_en <= wdata[M_EMPTY_EN];
        end
    end

    always_comb begin
        stat_word             = '0;
        stat_word[S_TX_DONE]  = tx_done_q;
        stat_word[S_RX_DONE]  = rx_done_q;
        stat_word[S_RX_PEND]  = rx_pend;
        stat_word[S_RX_LOW]   = rx_low;
        stat_word[S_TX_HIGH]  = tx_high;
        stat_word[S_TX_FULL]  = tx_full;
        stat_word[S_TX_EMPTY] = tx_empty;
        stat_word[S_DMA_IN]   = dma_in_armed;
        stat_word[S_DMA_OUT]  = dma_out_armed;
        stat_word[S_TX_OVF]   = ovf_q;
    end

    assign irq_rx = (rx_done_q | rx_pend) & ~dma_in_armed;
    assign irq_tx = (tx_done_q & ~tx_high) | (tx_empty & empty_en);
endmodule

// File: rtl/msg_chan_ctrl.sv
module msg_chan_ctrl
    import mcc_pkg::*;
#(
    parameter int OUT_DEPTH    = 60,
    parameter int IN_DEPTH     = 16,
    parameter int TX_HIGH_FREE = 4,
    parameter int RX_LOW_WORDS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic              dma_in_armed,
    input  logic              dma_out_armed,
    output logic              irq_rx,
    output logic              irq_tx
);
    localparam int OCNT_W = $clog2(OUT_DEPTH+1);
    localparam int ICNT_W = $clog2(IN_DEPTH+1);

    mcc_addr_e         adr;
    logic              wr, rd, fifo_port;
    logic              out_push, out_empty, out_full;
    logic              in_pop, in_empty, in_full, in_head_last;
    logic [WORD_W-1:0] in_head;
    logic [OCNT_W-1:0] out_count;
    logic [ICNT_W-1:0] in_count;
    logic [STAT_W-1:0] stat_word;
    logic              empty_en, tx_done_q, ovf_q, tx_empty_flag;
    logic              tx_close_evt, rx_close_evt, ovf_evt;

    assign adr       = mcc_addr_e'(host_addr);
    assign wr        = host_valid & host_write;
    assign rd        = host_valid & ~host_write;
    assign fifo_port = (adr == ADR_DATA) || (adr == ADR_CLOSE);
    assign out_push  = wr & fifo_port;
    assign ovf_evt   = out_push & out_full;
    assign in_pop    = rd & fifo_port;

    assign tx_valid     = ~out_empty;
    assign rx_ready     = ~in_full;
    assign tx_close_evt = tx_valid & tx_ready & tx_last;
    assign rx_close_evt = in_pop & ~in_empty & in_head_last;

    mcc_fifo #(.DEPTH(OUT_DEPTH), .W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .push(out_push), .push_data(host_wdata), .push_last(adr == ADR_CLOSE),
        .pop(tx_ready), .head_data(tx_data), .head_last(tx_last),
        .empty(out_empty), .full(out_full), .count(out_count)
    );

    mcc_fifo #(.DEPTH(IN_DEPTH), .W(WORD_W)) u_in (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid), .push_data(rx_data), .push_last(rx_last),
        .pop(in_pop), .head_data(in_head), .head_last(in_head_last),
        .empty(in_empty), .full(in_full), .count(in_count)
    );

    mcc_status #(
        .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH),
        .TX_HIGH_FREE(TX_HIGH_FREE), .RX_LOW_WORDS(RX_LOW_WORDS)
    ) u_stat (
        .clk(clk), .rst_n(rst_n),
        .tx_close_evt(tx_close_evt), .rx_close_evt(rx_close_evt), .ovf_evt(ovf_evt),
        .stat_wr(wr && adr == ADR_STAT), .mode_wr(wr && adr == ADR_MODE),
        .wdata(host_wdata), .out_count(out_count), .in_count(in_count),
        .dma_in_armed(dma_in_armed), .dma_out_armed(dma_out_armed),
        .stat_word(stat_word), .empty_en(empty_en), .tx_done_q(tx_done_q),
        .ovf_q(ovf_q), .tx_empty(tx_empty_flag), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    // registered read data, zero between reads
    always_ff @(posedge clk) begin
        if (!rst_n || !rd) begin
            host_rdata <= '0;
        end else begin
            unique case (adr)
                ADR_DATA, ADR_CLOSE: host_rdata <= in_empty ? '0 : in_head;
                ADR_STAT:            host_rdata <= WORD_W'(stat_word);
                ADR_MODE:            host_rdata <= WORD_W'(empty_en);
            endcase
        end
    end
endmodule

// File: rtl/msg_chan_ctrl_chk.sv
module msg_chan_ctrl_chk #(
    parameter int OUT_DEPTH = 60,
    parameter int OCNT_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_last,
    input logic              dma_in_armed,
    input logic              irq_rx,
    input logic              tx_done,
    input logic              ovf,
    input logic              tx_empty,
    input logic [OCNT_W-1:0] out_count,
    input logic              host_valid,
    input logic              host_write,
    input logic [1:0]        host_addr,
    input logic              wdata_ovf
);
    // R2
    tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !tx_valid);
    // R7
    tx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> tx_done);
    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(host_valid && host_write && host_addr == 2'd2 && wdata_ovf)) |=> ovf);
    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(out_count) == OUT_DEPTH && host_valid && host_write && !host_addr[1]) |=> ovf);
    // R8
    irq_rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_in_armed |-> !irq_rx);
endmodule

bind msg_chan_ctrl msg_chan_ctrl_chk #(.OUT_DEPTH(OUT_DEPTH), .OCNT_W(OCNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .dma_in_armed(dma_in_armed), .irq_rx(irq_rx),
    .tx_done(tx_done_q), .ovf(ovf_q), .tx_empty(tx_empty_flag),
    .out_count(out_count), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .wdata_ovf(host_wdata[16])
);

// File: tb/tb_msg_chan_ctrl.sv
module tb_msg_chan_ctrl;
    localparam int OUT_D = 60;
    localparam int IN_D  = 16;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic         host_valid = 1'b0, host_write = 1'b0;
    logic [1:0]   host_addr = '0;
    logic [127:0] host_wdata = '0, host_rdata;
    logic         tx_valid, tx_ready = 1'b0, tx_last;
    logic [127:0] tx_data, rx_data = '0;
    logic         rx_valid = 1'b0, rx_ready, rx_last = 1'b0;
    logic         dma_in_armed = 1'b0, dma_out_armed = 1'b0;
    logic         irq_rx, irq_tx;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [128:0] tx_q[$];
    logic [128:0] rx_q[$];

    always #2 clk = ~clk;

    msg_chan_ctrl dut (.*);

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] st(input int bits[$]);
        logic [127:0] v = '0;
        foreach (bits[i]) v[bits[i]] = 1'b1;
        return v;
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [127:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [127:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        d = host_rdata;
    endtask

    // driver: writes a word, expects it on the link if accepted
    task automatic put_word(input logic [127:0] d, input bit close, input bit accept);
        bus_wr(close ? 2'd1 : 2'd0, d);
        if (accept) tx_q.push_back({close, d});
    endtask

    task automatic link_send(input logic [127:0] d, input bit close);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_last = close;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        rx_q.push_back({close, d});
    endtask

    task automatic take_word(input logic [1:0] a, input string tag);
        logic [127:0] d;
        logic [128:0] e;
        bus_rd(a, d);
        e = (rx_q.size() != 0) ? rx_q.pop_front() : '0;
        chk(tag, d, e[127:0]);
    endtask

    task automatic stat_is(input string tag, input logic [127:0] exp);
        logic [127:0] d;
        bus_rd(2'd2, d);
        chk(tag, d, exp);
    endtask

    // monitor: outgoing words compared against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && tx_valid && tx_ready) begin
            if (tx_q.size() == 0) begin
                chk("R2 unexpected tx word", {127'd0, 1'b1}, '0);
            end else begin
                logic [128:0] e;
                e = tx_q.pop_front();
                chk("R2 tx data", tx_data, e[127:0]);
                chk("R2 tx last", {127'd0, tx_last}, {127'd0, e[128]});
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_valid", {127'd0, tx_valid}, '0);
        chk("R1 rx_ready", {127'd0, rx_ready}, 128'd1);
        chk("R1 irqs", {126'd0, irq_rx, irq_tx}, '0);
        stat_is("R1 status", 128'h1200);
        bus_rd(2'd3, d);
        chk("R1 mode", d, '0);

        // R2 ordering and close tag
        put_word(128'hA1, 1'b0, 1'b1);
        put_word(128'hA2, 1'b0, 1'b1);
        put_word(128'hA3, 1'b1, 1'b1);
        stat_is("R4 not empty", st('{9}));
        tx_ready = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 drained", tx_q.size(), 0);
        // R7 tx_done set, R9 irq_tx from it
        stat_is("R7 tx_done set", st('{6, 9, 12}));
        chk("R9 irq_tx done", {127'd0, irq_tx}, 128'd1);
        bus_wr(2'd2, '0);
        stat_is("R7 zero write keeps", st('{6, 9, 12}));
        bus_wr(2'd2, st('{6}));
        stat_is("R7 w1c clears", st('{9, 12}));
        chk("R9 irq_tx off", {127'd0, irq_tx}, '0);
        bus_wr(2'd3, 128'd1);
        bus_rd(2'd3, d);
        chk("R9 mode readback", d, 128'd1);
        chk("R9 irq_tx empty", {127'd0, irq_tx}, 128'd1);
        bus_wr(2'd3, 128'd0);

        // R3 R4 fill, almost-full, overflow
        put_word(128'hC0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        tx_ready = 1'b0;
        for (int i = 0; i < 55; i++) put_word(128'h1000 + 128'(i), 1'b0, 1'b1);
        stat_is("R4 55 words", st('{6, 9}));
        chk("R9 irq_tx at 55", {127'd0, irq_tx}, 128'd1);
        put_word(128'h2000, 1'b0, 1'b1);
        stat_is("R4 56 words", st('{6, 9, 10}));
        chk("R9 irq_tx gated", {127'd0, irq_tx}, '0);
        for (int i = 0; i < 4; i++) put_word(128'h3000 + 128'(i), i == 3, 1'b1);
        stat_is("R3 full", st('{6, 9, 10, 11}));
        put_word(128'hDEAD, 1'b0, 1'b0);
        stat_is("R3 overflow", st('{6, 9, 10, 11, 16}));
        tx_ready = 1'b1;
        repeat (70) @(negedge clk);
        chk("R3 drop not sent", tx_q.size(), 0);
        stat_is("R3 ovf sticky", st('{6, 9, 12, 16}));
        bus_wr(2'd2, st('{6, 16}));
        stat_is("R3 ovf cleared", st('{9, 12}));

        // R5 R6 R8 R10 incoming side
        link_send(128'hB1, 1'b0);
        stat_is("R6 one word", st('{8, 9, 12}));
        chk("R8 irq_rx pend", {127'd0, irq_rx}, 128'd1);
        link_send(128'hB2, 1'b1);
        dma_in_armed = 1'b1; dma_out_armed = 1'b1;
        stat_is("R10 dma bits", st('{8, 12, 13, 14}));
        chk("R8 irq_rx gated", {127'd0, irq_rx}, '0);
        dma_in_armed = 1'b0; dma_out_armed = 1'b0;
        take_word(2'd0, "R5 read data port");
        take_word(2'd1, "R5 read close port");
        stat_is("R7 rx_done set", st('{7, 9, 12}));
        chk("R8 irq_rx done", {127'd0, irq_rx}, 128'd1);
        bus_wr(2'd2, st('{7}));
        chk("R8 irq_rx cleared", {127'd0, irq_rx}, '0);
        take_word(2'd0, "R5 empty read zero");
        for (int i = 0; i < IN_D; i++) link_send(128'h5000 + 128'(i), 1'b0);
        chk("R5 rx_ready full", {127'd0, rx_ready}, '0);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 128'hBAD;
        @(negedge clk);
        rx_valid = 1'b0;
        for (int i = 0; i < IN_D; i++) take_word(2'd0, "R5 in-order read");
        take_word(2'd0, "R5 empty after full");
        stat_is("R6 drained", st('{9, 12}));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule